// File: doc/BRIEF.md
# Debug Mode Entry Controller

This block decides when a simple in-order processor core stops and enters debug mode, and how it leaves it. It watches four ways in: an active-low external request pin held across core reset, a request bit in a control register set during reset, a request raised while the core runs, and a request raised while the core sits in a waiting, halted or stopped low-power state. When it enters debug mode it holds the core's pipeline with a halt signal and raises a debug status bit. A request from a running core lets the current instruction finish and freezes the core once the next fetched instruction has reached the instruction register.

The block also tracks the core's low-power state. It records that state when debug mode begins and drives it out as a resume selector. On a debug-exit pulse it puts the core back into that state, or lets execution resume if the core was running. The pin is brought into the clock domain by a synchronizer. New requests are recognised on the rising edge of the combined request level, so a request that is held or raised during a debug session does not cause a second entry.

Top module: `dbg_entry_ctrl`

## Requirements
- R1: While dbg_en is low, no request path causes entry. Dropping dbg_en while an entry is still pending cancels it, and the core is never halted as a result.
- R2: If dbg_req_n is low during the last reset cycles and still low after reset is released, core_halt is already high in the first cycle after release and dbg_status rises one clock later. If the pin has been released long enough before reset ends, no entry happens.
- R3: dbg_req_n is active low and passes through a two-flop synchronizer. When the core is ready to stop, a pin falling after a clock edge raises dbg_status on the third following edge.
- R4: If ctl_dr is high during reset, debug mode is entered one clock after reset is released, even when ctl_dr is cleared at release.
- R5: A request while running waits for a retire strobe. It then waits for an ir_load strobe in the same cycle as that retire or in a later cycle. core_halt and dbg_status rise one clock after that load. An ir_load that comes before the retire does not count.
- R6: A request edge in the same cycle as retire counts that retire as done. If ir_load also comes in that cycle, debug mode is entered on the next clock.
- R7: A request in a low-power state drops st_waiting, st_halted and st_stopped on the next clock. Entry then waits for clk_ok. The three status outputs stay low while dbg_status is high.
- R8: resume_sel holds the low-power state captured when debug mode was entered: 00 running, 01 waiting, 10 halted, 11 stopped.
- R9: A dbg_exit pulse in debug mode clears dbg_status and core_halt on the next clock and reasserts the status output that matches resume_sel.
- R10: Requests raised or held during debug mode are ignored. After exit, a still-high request does not re-enter. Only a new rising edge of the combined request level does.
- R11: After a reset with no request pending, every output is low.
- R12: While running with no pending request, lp_req (01 waiting, 10 halted, 11 stopped) moves the core from running into that state, and lp_wake returns it to running. At most one status output is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Core reset, synchronous, active high |
| dbg_en | input | 1 | Debug logic enable |
| dbg_req_n | input | 1 | External debug request pin, active low, asynchronous |
| ctl_dr | input | 1 | Debug request bit from the control register |
| retire | input | 1 | Current instruction completed |
| ir_load | input | 1 | Instruction register loaded with a fetched instruction |
| lp_req | input | 2 | Low-power state request code |
| lp_wake | input | 1 | Normal wake-up from low-power state |
| clk_ok | input | 1 | Core clock has been restored |
| dbg_exit | input | 1 | End of debug session pulse |
| core_halt | output | 1 | Hold the pipeline |
| dbg_status | output | 1 | Debug mode status bit |
| st_waiting | output | 1 | Core is waiting |
| st_halted | output | 1 | Core is halted |
| st_stopped | output | 1 | Core is stopped |
| resume_sel | output | 2 | Captured low-power state to return to |

## Verification
Two pairs of events can fall in the same cycle: a request edge with the retire strobe, and a retire strobe with the instruction register load. The bench raises ctl_dr together with retire and ir_load and expects entry on the very next clock. It also raises ctl_dr together with retire alone and expects the controller to skip straight to waiting for the load. A behavioural model in the bench judges every cycle, and directed checks confirm that an ir_load seen before the retire is not taken as the stopping point.

// File: rtl/dbg_entry_pkg.sv
package dbg_entry_pkg;

    localparam int LP_W = 2;

    typedef enum logic [2:0] {
        ST_RUN       = 3'd0,
        ST_RSTCHK    = 3'd1,
        ST_DRAIN_RET = 3'd2,
        ST_DRAIN_IR  = 3'd3,
        ST_WAKE      = 3'd4,
        ST_DEBUG     = 3'd5
    } dbg_state_e;

    typedef enum logic [LP_W-1:0] {
        LP_RUN  = 2'b00,
        LP_WAIT = 2'b01,
        LP_HALT = 2'b10,
        LP_STOP = 2'b11
    } lp_code_e;

    typedef struct packed {
        logic waiting;
        logic halted;
        logic stopped;
    } lp_flags_t;

    typedef struct packed {
        logic pin;
        logic regbit;
    } rst_src_t;

    function automatic lp_flags_t lp_decode(lp_code_e code);
        lp_flags_t f;
        f.waiting = (code == LP_WAIT);
        f.halted  = (code == LP_HALT);
        f.stopped = (code == LP_STOP);
        return f;
    endfunction

    function automatic logic is_halting(dbg_state_e s);
        return (s == ST_RSTCHK) || (s == ST_DEBUG);
    endfunction

endpackage

// File: rtl/dbg_pin_sync.sv
module dbg_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic pin_n,
    output logic act
);
    logic [STAGES-1:0] sh;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) sh[i] <= pin_n;
        end else begin : g_next
            always_ff @(posedge clk) sh[i] <= sh[i-1];
        end
    end

    assign act = ~sh[STAGES-1];
endmodule

// File: rtl/dbg_req_detect.sv
module dbg_req_detect (
    input  logic clk,
    input  logic en,
    input  logic pin_act,
    input  logic reg_req,
    output logic lvl,
    output logic rise
);
    logic lvl_d;

    assign lvl = en && (pin_act || reg_req);

    always_ff @(posedge clk) lvl_d <= lvl;

    assign rise = lvl && !lvl_d;
endmodule

// File: rtl/dbg_entry_fsm.sv
module dbg_entry_fsm
    import dbg_entry_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic       pin_act,
    input  logic       reg_req,
    input  logic       req_lvl,
    input  logic       req_rise,
    input  logic       retire,
    input  logic       ir_load,
    input  logic       lp_busy,
    input  logic       clk_ok,
    input  logic       dbg_exit,
    output dbg_state_e state,
    output logic       enter_dbg,
    output logic       exit_dbg,
    output logic       lp_allow
);
    dbg_state_e nxt;
    rst_src_t   src;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_RUN: begin
                if (req_rise) begin
                    if (lp_busy)                nxt = ST_WAKE;
                    else if (retire && ir_load) nxt = ST_DEBUG;
                    else if (retire)            nxt = ST_DRAIN_IR;
                    else                        nxt = ST_DRAIN_RET;
                end
            end
            ST_RSTCHK: begin
                nxt = (src.regbit || (src.pin && pin_act)) ? ST_DEBUG : ST_RUN;
            end
            ST_DRAIN_RET: begin
                if (!en)                    nxt = ST_RUN;
                else if (retire && ir_load) nxt = ST_DEBUG;
                else if (retire)            nxt = ST_DRAIN_IR;
            end
            ST_DRAIN_IR: begin
                if (!en)          nxt = ST_RUN;
                else if (ir_load) nxt = ST_DEBUG;
            end
            ST_WAKE: begin
                if (!en)         nxt = ST_RUN;
                else if (clk_ok) nxt = ST_DEBUG;
            end
            ST_DEBUG: begin
                if (dbg_exit) nxt = ST_RUN;
            end
            default: nxt = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= req_lvl ? ST_RSTCHK : ST_RUN;
            src   <= '{pin: en && pin_act, regbit: en && reg_req};
        end else begin
            state <= nxt;
        end
    end

    assign enter_dbg = (nxt == ST_DEBUG) && (state != ST_DEBUG);
    assign exit_dbg  = (state == ST_DEBUG) && (nxt != ST_DEBUG);
    assign lp_allow  = (state == ST_RUN) && !req_rise;
endmodule

// File: rtl/dbg_lp_track.sv
module dbg_lp_track
    import dbg_entry_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      enter_dbg,
    input  logic      exit_dbg,
    input  logic      allow,
    input  logic      show,
    input  logic      lp_wake,
    input  lp_code_e  lp_req,
    output logic      busy,
    output lp_flags_t flags,
    output lp_code_e  saved
);
    lp_code_e cur;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur   <= LP_RUN;
            saved <= LP_RUN;
        end else if (enter_dbg) begin
            saved <= cur;
            cur   <= LP_RUN;
        end else if (exit_dbg) begin
            cur <= saved;
        end else if (allow) begin
            if (lp_wake)
                cur <= LP_RUN;
            else if (cur == LP_RUN && lp_req != LP_RUN)
                cur <= lp_req;
        end
    end

    assign busy  = (cur != LP_RUN);
    assign flags = show ? lp_decode(cur) : '0;
endmodule

// File: rtl/dbg_entry_ctrl.sv
module dbg_entry_ctrl
    import dbg_entry_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       dbg_en,
    input  logic       dbg_req_n,
    input  logic       ctl_dr,
    input  logic       retire,
    input  logic       ir_load,
    input  logic [1:0] lp_req,
    input  logic       lp_wake,
    input  logic       clk_ok,
    input  logic       dbg_exit,
    output logic       core_halt,
    output logic       dbg_status,
    output logic       st_waiting,
    output logic       st_halted,
    output logic       st_stopped,
    output logic [1:0] resume_sel
);
    logic       pin_act;
    logic       req_lvl;
    logic       req_rise;
    logic       lp_busy;
    logic       enter_dbg;
    logic       exit_dbg;
    logic       lp_allow;
    dbg_state_e fsm_state;
    lp_flags_t  flags;
    lp_code_e   saved;

    dbg_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .pin_n (dbg_req_n),
        .act   (pin_act)
    );

    dbg_req_detect u_req (
        .clk     (clk),
        .en      (dbg_en),
        .pin_act (pin_act),
        .reg_req (ctl_dr),
        .lvl     (req_lvl),
        .rise    (req_rise)
    );

    dbg_entry_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .en        (dbg_en),
        .pin_act   (pin_act),
        .reg_req   (ctl_dr),
        .req_lvl   (req_lvl),
        .req_rise  (req_rise),
        .retire    (retire),
        .ir_load   (ir_load),
        .lp_busy   (lp_busy),
        .clk_ok    (clk_ok),
        .dbg_exit  (dbg_exit),
        .state     (fsm_state),
        .enter_dbg (enter_dbg),
        .exit_dbg  (exit_dbg),
        .lp_allow  (lp_allow)
    );

    dbg_lp_track u_lp (
        .clk       (clk),
        .rst       (rst),
        .enter_dbg (enter_dbg),
        .exit_dbg  (exit_dbg),
        .allow     (lp_allow),
        .show      (fsm_state != ST_WAKE),
        .lp_wake   (lp_wake),
        .lp_req    (lp_code_e'(lp_req)),
        .busy      (lp_busy),
        .flags     (flags),
        .saved     (saved)
    );

    assign core_halt  = is_halting(fsm_state);
    assign dbg_status = (fsm_state == ST_DEBUG);
    assign st_waiting = flags.waiting;
    assign st_halted  = flags.halted;
    assign st_stopped = flags.stopped;
    assign resume_sel = saved;
endmodule

// File: rtl/dbg_entry_checker.sv
module dbg_entry_checker
    import dbg_entry_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       dbg_en,
    input logic       ir_load,
    input logic       clk_ok,
    input logic       dbg_exit,
    input logic       core_halt,
    input logic       dbg_status,
    input logic       st_waiting,
    input logic       st_halted,
    input logic       st_stopped,
    input dbg_state_e state
);
    assert_no_entry_when_disabled_R1: assert property (@(posedge clk) disable iff (rst)
        (!core_halt && !dbg_en) |=> !core_halt);

    assert_irload_gate_R5: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DRAIN_IR && !ir_load) |=> !dbg_status);

    assert_clock_gate_R7: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAKE && !clk_ok) |=> !dbg_status);

    assert_quiet_in_debug_R7: assert property (@(posedge clk) disable iff (rst)
        dbg_status |-> !(st_waiting || st_halted || st_stopped));

    assert_exit_release_R9: assert property (@(posedge clk) disable iff (rst)
        (dbg_status && dbg_exit) |=> (!dbg_status && !core_halt));

    assert_debug_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (dbg_status && !dbg_exit) |=> dbg_status);

    assert_single_status_R12: assert property (@(posedge clk) disable iff (rst)
        $onehot0({st_waiting, st_halted, st_stopped}));
endmodule

bind dbg_entry_ctrl dbg_entry_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .dbg_en     (dbg_en),
    .ir_load    (ir_load),
    .clk_ok     (clk_ok),
    .dbg_exit   (dbg_exit),
    .core_halt  (core_halt),
    .dbg_status (dbg_status),
    .st_waiting (st_waiting),
    .st_halted  (st_halted),
    .st_stopped (st_stopped),
    .state      (fsm_state)
);

// File: tb/dbg_entry_ctrl_bench.sv
module dbg_entry_ctrl_bench;
    timeunit 1ns;
    timeprecision 1ps;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic       rst = 1'b1, dbg_en = 1'b0, dbg_req_n = 1'b1, ctl_dr = 1'b0;
    logic       retire = 1'b0, ir_load = 1'b0, lp_wake = 1'b0, clk_ok = 1'b0, dbg_exit = 1'b0;
    logic [1:0] lp_req = 2'b00;
    logic       core_halt, dbg_status, st_waiting, st_halted, st_stopped;
    logic [1:0] resume_sel;

    dbg_entry_ctrl u_dbg_entry_ctrl (
        .clk(clk), .rst(rst), .dbg_en(dbg_en), .dbg_req_n(dbg_req_n), .ctl_dr(ctl_dr),
        .retire(retire), .ir_load(ir_load), .lp_req(lp_req), .lp_wake(lp_wake),
        .clk_ok(clk_ok), .dbg_exit(dbg_exit), .core_halt(core_halt), .dbg_status(dbg_status),
        .st_waiting(st_waiting), .st_halted(st_halted), .st_stopped(st_stopped),
        .resume_sel(resume_sel)
    );

    int    n_chk = 0;
    int    n_bad = 0;
    bit    done = 0;
    bit    cmp_on = 0;
    string tag = "R11";

    // Behavioural model: 0 run, 1 reset check, 2 await retire, 3 await load, 4 wake, 5 debug
    int m_st = 0, m_cur = 0, m_saved = 0;
    bit m_s1 = 0, m_s2 = 0, m_lvl_d = 0, m_srcp = 0, m_srcr = 0;

    always @(posedge clk) begin : model
        int nst;
        bit pa, lvl, rise;
        pa   = !m_s2;
        lvl  = dbg_en && (pa || ctl_dr);
        rise = lvl && !m_lvl_d;
        if (rst) begin
            m_st = lvl ? 1 : 0;
            m_srcp = dbg_en && pa;
            m_srcr = dbg_en && ctl_dr;
            m_cur = 0;
            m_saved = 0;
        end else begin
            nst = m_st;
            if (m_st == 0) begin
                if (rise) nst = (m_cur != 0) ? 4 : (retire && ir_load) ? 5 : retire ? 3 : 2;
                else if (lp_wake) m_cur = 0;
                else if (m_cur == 0 && lp_req != 0) m_cur = int'(lp_req);
            end else if (m_st == 1) nst = (m_srcr || (m_srcp && pa)) ? 5 : 0;
            else if (m_st == 2) nst = !dbg_en ? 0 : (retire && ir_load) ? 5 : retire ? 3 : 2;
            else if (m_st == 3) nst = !dbg_en ? 0 : ir_load ? 5 : 3;
            else if (m_st == 4) nst = !dbg_en ? 0 : clk_ok ? 5 : 4;
            else if (m_st == 5 && dbg_exit) nst = 0;
            if (nst == 5 && m_st != 5) begin m_saved = m_cur; m_cur = 0; end
            if (m_st == 5 && nst != 5) m_cur = m_saved;
            m_st = nst;
        end
        m_lvl_d = lvl;
        m_s2 = m_s1;
        m_s1 = dbg_req_n;
    end

    function automatic logic [6:0] model_vec();
        logic [2:0] fl;
        fl = (m_st == 4 || m_cur == 0) ? 3'b000 : 3'(3'b100 >> (m_cur - 1));
        return {(m_st == 1 || m_st == 5), (m_st == 5), fl, 2'(m_saved)};
    endfunction

    always @(negedge clk) begin
        if (cmp_on) begin
            logic [6:0] act;
            act = {core_halt, dbg_status, st_waiting, st_halted, st_stopped, resume_sel};
            n_chk++;
            if (act !== model_vec()) begin
                n_bad++;
                $display("FAIL %s model compare actual=%b expected=%b", tag, act, model_vec());
            end
        end
    end

    task automatic check(string req, string what, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) begin @(negedge clk); #1; end
    endtask

    task automatic leave_debug();
        dbg_exit = 1'b1; cyc(1); dbg_exit = 1'b0;
    endtask

    initial begin
        cyc(1);
        cmp_on = 1;
        // R11: reset state
        cyc(2); dbg_en = 1'b1; cyc(1); rst = 1'b0; cyc(1);
        check("R11", "outputs after reset", {1'b0, core_halt, dbg_status, st_waiting, st_halted, st_stopped, resume_sel}, 8'h00);

        // R1: disabled requests are ignored, pending entry cancelled
        tag = "R1";
        dbg_en = 1'b0; ctl_dr = 1'b1; dbg_req_n = 1'b0; cyc(5);
        check("R1", "halt while disabled", {7'd0, core_halt}, 8'd0);
        check("R1", "debug while disabled", {7'd0, dbg_status}, 8'd0);
        ctl_dr = 1'b0; dbg_req_n = 1'b1; cyc(3); dbg_en = 1'b1; cyc(1);
        ctl_dr = 1'b1; cyc(1); dbg_en = 1'b0; cyc(1);
        ctl_dr = 1'b0; retire = 1'b1; ir_load = 1'b1; cyc(1); retire = 1'b0; ir_load = 1'b0;
        check("R1", "cancelled entry", {7'd0, dbg_status}, 8'd0);
        dbg_en = 1'b1; cyc(1);

        // R2: pin held across reset
        tag = "R2";
        dbg_req_n = 1'b0; rst = 1'b1; cyc(4);
        rst = 1'b0;
        check("R2", "halt at reset release", {7'd0, core_halt}, 8'd1);
        cyc(1);
        check("R2", "debug after release", {6'd0, core_halt, dbg_status}, 8'd3);
        dbg_req_n = 1'b1; cyc(3);
        check("R2", "debug held", {7'd0, dbg_status}, 8'd1);
        leave_debug();
        check("R9", "exit releases", {6'd0, core_halt, dbg_status}, 8'd0);

        // R2: pin released before reset ends
        dbg_req_n = 1'b0; rst = 1'b1; cyc(4);
        dbg_req_n = 1'b1; cyc(2); rst = 1'b0; cyc(3);
        check("R2", "released pin no entry", {6'd0, core_halt, dbg_status}, 8'd0);

        // R4: register bit during reset
        tag = "R4";
        ctl_dr = 1'b1; rst = 1'b1; cyc(3);
        ctl_dr = 1'b0; rst = 1'b0; cyc(1);
        check("R4", "entry after reset", {7'd0, dbg_status}, 8'd1);
        leave_debug();

        // R5: request during normal execution
        tag = "R5";
        ctl_dr = 1'b1; cyc(1); ctl_dr = 1'b0; cyc(2);
        check("R5", "waiting for retire", {7'd0, dbg_status}, 8'd0);
        ir_load = 1'b1; cyc(1); ir_load = 1'b0;
        check("R5", "load before retire", {7'd0, dbg_status}, 8'd0);
        retire = 1'b1; cyc(1); retire = 1'b0; cyc(2);
        check("R5", "waiting for load", {7'd0, dbg_status}, 8'd0);
        ir_load = 1'b1; cyc(1); ir_load = 1'b0;
        check("R5", "entry after load", {6'd0, core_halt, dbg_status}, 8'd3);
        leave_debug();

        // R6: coincident strobes
        tag = "R6";
        ctl_dr = 1'b1; retire = 1'b1; ir_load = 1'b1; cyc(1);
        ctl_dr = 1'b0; retire = 1'b0; ir_load = 1'b0;
        check("R6", "request+retire+load", {7'd0, dbg_status}, 8'd1);
        leave_debug();
        ctl_dr = 1'b1; retire = 1'b1; cyc(1); ctl_dr = 1'b0; retire = 1'b0;
        check("R6", "request+retire", {7'd0, dbg_status}, 8'd0);
        ir_load = 1'b1; cyc(1); ir_load = 1'b0;
        check("R6", "load after coincident retire", {7'd0, dbg_status}, 8'd1);
        leave_debug();

        // R7, R8, R9, R12: low-power entry and return
        for (int c = 1; c <= 3; c++) begin
            logic [2:0] fl;
            fl = 3'(3'b100 >> (c - 1));
            tag = "R12";
            lp_req = 2'(c); cyc(1); lp_req = 2'b00;
            check("R12", "enter low-power", {5'd0, st_waiting, st_halted, st_stopped}, {5'd0, fl});
            tag = "R7";
            ctl_dr = 1'b1; cyc(1); ctl_dr = 1'b0;
            check("R7", "status dropped", {5'd0, st_waiting, st_halted, st_stopped}, 8'd0);
            cyc(3);
            check("R7", "waits for clock", {7'd0, dbg_status}, 8'd0);
            clk_ok = 1'b1; cyc(1); clk_ok = 1'b0;
            check("R7", "entry after clock", {7'd0, dbg_status}, 8'd1);
            check("R8", "resume code", {6'd0, resume_sel}, 8'(c));
            tag = "R9";
            leave_debug();
            check("R9", "exit releases", {6'd0, core_halt, dbg_status}, 8'd0);
            check("R9", "state restored", {5'd0, st_waiting, st_halted, st_stopped}, {5'd0, fl});
            tag = "R12";
            lp_wake = 1'b1; cyc(1); lp_wake = 1'b0;
            check("R12", "wake to running", {5'd0, st_waiting, st_halted, st_stopped}, 8'd0);
        end

        // R10: requests in debug ignored
        tag = "R10";
        ctl_dr = 1'b1; retire = 1'b1; ir_load = 1'b1; cyc(1); retire = 1'b0; ir_load = 1'b0;
        check("R10", "entry", {7'd0, dbg_status}, 8'd1);
        ctl_dr = 1'b0; cyc(1); ctl_dr = 1'b1; dbg_req_n = 1'b0; cyc(4);
        check("R10", "still in debug", {7'd0, dbg_status}, 8'd1);
        leave_debug();
        retire = 1'b1; ir_load = 1'b1; cyc(4);
        check("R10", "no re-entry on held request", {6'd0, core_halt, dbg_status}, 8'd0);
        ctl_dr = 1'b0; dbg_req_n = 1'b1; retire = 1'b0; ir_load = 1'b0; cyc(4);

        // R3: synchronizer latency
        tag = "R3";
        retire = 1'b1; ir_load = 1'b1; dbg_req_n = 1'b0; cyc(2);
        check("R3", "not yet through synchronizer", {7'd0, dbg_status}, 8'd0);
        cyc(1);
        check("R3", "entry on third edge", {7'd0, dbg_status}, 8'd1);
        dbg_req_n = 1'b1; retire = 1'b0; ir_load = 1'b0; cyc(3);
        leave_debug(); cyc(2);

        done = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog all actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule